// File: doc/BRIEF.md
# Stop-Bit Field Stream Decoder

This block turns a compressed market-data byte stream into complete message records. Bytes arrive as 8-byte frames on a valid/ready input, where byte lane 0 (`in_data[7:0]`) is the earliest byte. A frame with `in_last` set closes a packet. Each packet opens with a short header. The header is followed by a counted run of messages. Every message carries a presence map, a type and a set of variable-length fields. In those fields each byte holds seven payload bits and a terminator flag.

A message has eight 32-bit field slots. A field the message omits is rebuilt from the slot's value in the previous message. Depending on a per-slot operator fixed at build time, that value is either kept as it is or increased by one. Fields may straddle frame boundaries. The parser walks all eight byte lanes of a frame in one cycle. It holds a frame for a further cycle only when a message finishes before the frame's last lane, so that a single output transfer carries one record.

Top module: `sbd_stream_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and every stored previous field value is 0. A first message with no fields present therefore yields 0 in copy slots and 1 in increment slots.
- R2: A packet's first byte must equal `SOH_CODE` (default 8'h01). Otherwise the whole packet is ignored up to its `in_last` frame, and no record or stored value changes. The second header byte, a version, is ignored.
- R3: In a terminated field, bit 7 set marks the final byte and bits 6:0 carry payload. The value is the 7-bit groups joined first-group-most-significant and truncated to 32 bits. Leading all-zero groups are accepted.
- R4: A field, the header and a message may each span any number of consecutive frames without changing the decoded values.
- R5: The presence map is a terminated field. Payload bit 6 of its first byte selects slot 0 and bit 0 selects slot 6, and bit 6 of its second byte selects slot 7. Slots with no map bit are absent. The message-size field before it is skipped.
- R6: An absent slot takes its previous value when its `INC_MASK` bit is 0 (default 8'b0000_1010). When that bit is 1, it takes the previous value plus one, modulo 2^32.
- R7: When bit `RAW_TYPE_BIT` (default 0) of the message type is 1, present slots flagged in `RAW_MASK` (default slots 6 and 7) are read as `RAW_BYTES` (default 4) plain bytes, most significant first.
- R8: Each finished message produces one transfer carrying all eight slots in `out_fields` (slot i at bits 32i+31:32i) and the type in `out_type`. `out_seq` is the header sequence number plus the message's index in the packet. The sequence number is a terminated field and the message count is a plain byte.
- R9: An offered frame is accepted in the same cycle unless the output is stalled, or unless a message completes on a lane other than the last. In that case the frame is taken one cycle later, and parsing resumes at the next lane.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and the record stay unchanged.
- R11: Once the header's message count has been used up, the remaining bytes of the packet are ignored. The frame after `in_last` begins a new header.
- R12: A message count of 0 produces no record for that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Frame taken this cycle |
| in_data | input | 64 | Frame bytes, lane 0 in bits 7:0 is first |
| in_last | input | 1 | Frame closes the packet |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_seq | output | 32 | Sequence number of the record |
| out_type | output | 8 | Message type |
| out_fields | output | 256 | Eight 32-bit field slots |

## Verification
On every cycle the assertions check the output handshake. The record holds steady and in-flight under backpressure, input is refused while the output is blocked, and every refused frame on an unblocked output is followed by a record. Field decoding, the presence-map bit order, the copy and increment operators, plain-byte slots, packet rejection and count exhaustion depend on byte content over many cycles. Only the bench's packets, checked against a reference model, can show them. The single-cycle frame rate is shown by timing a directed packet whose one message ends on lane 6.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
   localparam int SBD_NF  = 8;                 // field slots
   localparam int SBD_FW  = 32;                // slot width
   localparam int SBD_SW  = 32;                // sequence width
   localparam int SBD_TW  = 8;                 // message type width
   localparam int SBD_FSW = $clog2(SBD_NF);    // slot index width
   localparam int SBD_RCW = 3;                 // plain byte counter width
   localparam int SBD_PMW = 4;                 // presence map byte counter width
   localparam int SBD_RW  = SBD_SW + SBD_TW + SBD_NF * SBD_FW;

   typedef enum logic [3:0] {
      PH_SOH, PH_VER, PH_SEQ, PH_CNT, PH_MSZ, PH_PMAP, PH_TYPE, PH_FLD, PH_DISC
   } phase_e;

   typedef struct packed {
      phase_e                            ph;
      logic [7:0]                        cnt;
      logic [SBD_SW-1:0]                 seq;
      logic [SBD_TW-1:0]                 mtype;
      logic [SBD_NF-1:0]                 pmap;
      logic [SBD_PMW-1:0]                pmb;
      logic [SBD_FSW-1:0]                fidx;
      logic [SBD_RCW-1:0]                rawc;
      logic [SBD_NF-1:0][SBD_FW-1:0]     cur;
   } pstate_t;
endpackage

// File: rtl/sbd_byte_step.sv
module sbd_byte_step
   import sbd_pkg::*;
#(
   parameter logic [7:0]        SOH_CODE     = 8'h01,
   parameter logic [SBD_NF-1:0] INC_MASK     = 8'b0000_1010,
   parameter logic [SBD_NF-1:0] RAW_MASK     = 8'b1100_0000,
   parameter int                RAW_BYTES    = 4,
   parameter int                RAW_TYPE_BIT = 0
) (
   input  logic       en,
   input  logic [7:0] byte_i,
   input  pstate_t    s_i,
   output pstate_t    s_o,
   output logic       done_o
);
   localparam logic [SBD_FSW:0] NONE = (SBD_FSW+1)'(SBD_NF);

   function automatic logic [SBD_FSW:0] first_set(input logic [SBD_NF-1:0] pm, input int from);
      logic [SBD_FSW:0] r;
      r = NONE;
      for (int i = SBD_NF-1; i >= 0; i--)
         if (i >= from && pm[i]) r = (SBD_FSW+1)'(i);
      return r;
   endfunction

   logic [SBD_FSW:0] nx;
   logic             fin, fin_f, raw;

   always_comb begin
      s_o    = s_i;
      done_o = 1'b0;
      nx     = NONE;
      fin    = 1'b0;
      fin_f  = 1'b0;
      raw    = 1'b0;
      if (en) begin
         case (s_i.ph)
            PH_SOH: s_o.ph = (byte_i == SOH_CODE) ? PH_VER : PH_DISC;
            PH_VER: begin
               s_o.seq = '0;
               s_o.ph  = PH_SEQ;
            end
            PH_SEQ: begin
               s_o.seq = {s_i.seq[SBD_SW-8:0], byte_i[6:0]};
               if (byte_i[7]) s_o.ph = PH_CNT;
            end
            PH_CNT: begin
               s_o.cnt = byte_i;
               s_o.ph  = (byte_i == 8'd0) ? PH_DISC : PH_MSZ;
            end
            PH_MSZ: if (byte_i[7]) begin
               s_o.ph   = PH_PMAP;
               s_o.pmap = '0;
               s_o.pmb  = '0;
            end
            PH_PMAP: begin
               for (int i = 0; i < SBD_NF; i++)
                  for (int bb = 0; bb < 7; bb++)
                     if (int'(s_i.pmb) * 7 + bb == i) s_o.pmap[i] = byte_i[6-bb];
               if (s_i.pmb != '1) s_o.pmb = s_i.pmb + 1'b1;
               if (byte_i[7]) begin
                  s_o.ph    = PH_TYPE;
                  s_o.mtype = '0;
               end
            end
            PH_TYPE: begin
               s_o.mtype = {s_i.mtype[SBD_TW-8:0], byte_i[6:0]};
               if (byte_i[7]) begin
                  for (int i = 0; i < SBD_NF; i++)
                     s_o.cur[i] = s_i.pmap[i] ? '0 :
                                  (INC_MASK[i] ? s_i.cur[i] + 1'b1 : s_i.cur[i]);
                  nx       = first_set(s_i.pmap, 0);
                  s_o.rawc = '0;
                  if (nx == NONE) fin = 1'b1;
                  else begin
                     s_o.ph   = PH_FLD;
                     s_o.fidx = nx[SBD_FSW-1:0];
                  end
               end
            end
            PH_FLD: begin
               raw = RAW_MASK[s_i.fidx] && s_i.mtype[RAW_TYPE_BIT];
               if (raw) begin
                  s_o.cur[s_i.fidx] = {s_i.cur[s_i.fidx][SBD_FW-9:0], byte_i};
                  s_o.rawc          = s_i.rawc + 1'b1;
                  fin_f             = (s_i.rawc == SBD_RCW'(RAW_BYTES - 1));
               end else begin
                  s_o.cur[s_i.fidx] = {s_i.cur[s_i.fidx][SBD_FW-8:0], byte_i[6:0]};
                  fin_f             = byte_i[7];
               end
               if (fin_f) begin
                  nx       = first_set(s_i.pmap, int'(s_i.fidx) + 1);
                  s_o.rawc = '0;
                  if (nx == NONE) fin = 1'b1;
                  else s_o.fidx = nx[SBD_FSW-1:0];
               end
            end
            default: ;
         endcase
         if (fin) begin
            done_o  = 1'b1;
            s_o.seq = s_i.seq + 1'b1;
            s_o.cnt = s_i.cnt - 1'b1;
            s_o.ph  = (s_i.cnt == 8'd1) ? PH_DISC : PH_MSZ;
         end
      end
   end
endmodule

// File: rtl/sbd_out_hold.sv
module sbd_out_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         q     <= '0;
      end else if (load) begin
         valid <= 1'b1;
         q     <= d;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/sbd_stream_decoder.sv
module sbd_stream_decoder
   import sbd_pkg::*;
#(
   parameter int                NB           = 8,
   parameter logic [7:0]        SOH_CODE     = 8'h01,
   parameter logic [SBD_NF-1:0] INC_MASK     = 8'b0000_1010,
   parameter logic [SBD_NF-1:0] RAW_MASK     = 8'b1100_0000,
   parameter int                RAW_BYTES    = 4,
   parameter int                RAW_TYPE_BIT = 0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [NB*8-1:0]          in_data,
   input  logic                     in_last,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [SBD_SW-1:0]        out_seq,
   output logic [SBD_TW-1:0]        out_type,
   output logic [SBD_NF*SBD_FW-1:0] out_fields
);
   localparam int POSW = $clog2(NB);

   if (NB < 2)                         begin : g_bad_nb   $error("NB must be at least 2");              end
   if (RAW_BYTES < 1 || RAW_BYTES * 8 > SBD_FW || RAW_BYTES > 7)
                                       begin : g_bad_raw  $error("RAW_BYTES out of range");             end
   if (RAW_TYPE_BIT < 0 || RAW_TYPE_BIT >= SBD_TW)
                                       begin : g_bad_tbit $error("RAW_TYPE_BIT outside type width");    end

   pstate_t           st_q;
   logic [POSW-1:0]   pos_q, pos_n;
   pstate_t           ls [NB+1];
   logic              dsum [NB+1];
   logic              en_l [NB];
   logic              dn_l [NB];
   logic              blocked, go, hold, any_done;
   logic [SBD_RW-1:0] rec, rec_q;

   assign blocked = out_valid && !out_ready;
   assign go      = in_valid && !blocked;
   assign ls[0]   = st_q;
   assign dsum[0] = 1'b0;

   for (genvar k = 0; k < NB; k++) begin : g_lane
      assign en_l[k] = go && (POSW'(k) >= pos_q) && !dsum[k];
      sbd_byte_step #(
         .SOH_CODE(SOH_CODE), .INC_MASK(INC_MASK), .RAW_MASK(RAW_MASK),
         .RAW_BYTES(RAW_BYTES), .RAW_TYPE_BIT(RAW_TYPE_BIT)
      ) u_step (
         .en(en_l[k]), .byte_i(in_data[8*k +: 8]), .s_i(ls[k]),
         .s_o(ls[k+1]), .done_o(dn_l[k])
      );
      assign dsum[k+1] = dsum[k] || (en_l[k] && dn_l[k]);
   end

   assign hold     = dsum[NB-1];
   assign any_done = dsum[NB];
   assign in_ready = !blocked && !hold;

   always_comb begin
      pos_n = '0;
      for (int k = 0; k < NB-1; k++)
         if (dsum[k+1] && !dsum[k]) pos_n = POSW'(k + 1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= '0;
         st_q.ph <= PH_SOH;
         pos_q   <= '0;
      end else if (go) begin
         st_q <= ls[NB];
         if (hold) pos_q <= pos_n;
         else begin
            pos_q <= '0;
            if (in_last) st_q.ph <= PH_SOH;
         end
      end
   end

   assign rec = {ls[NB].seq - 1'b1, ls[NB].mtype, ls[NB].cur};

   sbd_out_hold #(.W(SBD_RW)) u_out (
      .clk(clk), .rst(rst), .load(any_done), .d(rec),
      .ready(out_ready), .valid(out_valid), .q(rec_q)
   );

   assign {out_seq, out_type, out_fields} = rec_q;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker
   import sbd_pkg::*;
(
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic [SBD_SW-1:0]        out_seq,
   input logic [SBD_TW-1:0]        out_type,
   input logic [SBD_NF*SBD_FW-1:0] out_fields
);
   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R1
   AST_OUT_KEPT:         assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |=> out_valid); // R10
   AST_OUT_STABLE:       assert property (@(posedge clk) disable iff (rst)
                            out_valid && !out_ready |=> $stable({out_seq, out_type, out_fields})); // R10
   AST_NO_TAKE_BLOCKED:  assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |-> !in_ready); // R9
   AST_STALL_EMITS:      assert property (@(posedge clk) disable iff (rst)
                            in_valid && !in_ready && !(out_valid && !out_ready) |=> out_valid); // R9
endmodule

bind sbd_stream_decoder sbd_checker u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .out_seq(out_seq), .out_type(out_type), .out_fields(out_fields)
);

// File: tb/sim_sbd_stream_decoder.sv
module sim_sbd_stream_decoder;
   localparam int              DW  = 32 + 8 + 8 * 32;
   localparam logic [7:0]      INC = 8'b0000_1010;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [63:0]   in_data = '0;
   logic          in_ready, out_valid;
   logic [31:0]   out_seq;
   logic [7:0]    out_type;
   logic [255:0]  out_fields;
   wire [DW-1:0]  outall = {out_seq, out_type, out_fields};

   int total = 0, fails = 0;
   logic [7:0]        bq[$];
   logic [63:0]       fq_data[$];
   bit                fq_last[$];
   logic [DW-1:0]     eq[$];
   string             tq[$];
   logic [7:0][31:0]  pv = '0;
   string             tag;

   always #4 clk = ~clk;

   sbd_stream_decoder #(.NB(8), .SOH_CODE(8'h01), .INC_MASK(INC), .RAW_MASK(8'b1100_0000),
                        .RAW_BYTES(4), .RAW_TYPE_BIT(0)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
      .out_seq(out_seq), .out_type(out_type), .out_fields(out_fields));

   task automatic check(input bit ok, input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h", t, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      bq.push_back(b);
   endtask

   task automatic put_sb(input logic [31:0] v, input int zpad);
      int n;
      logic [7:0] b;
      n = 1;
      for (int z = 0; z < zpad; z++) put(8'h00);
      while (n < 5 && (v >> (7 * n)) != 0) n++;
      for (int g = n - 1; g >= 0; g--) begin
         b = {(g == 0), 7'(v >> (7 * g))};
         put(b);
      end
   endtask

   task automatic hdr(input logic [7:0] soh, input logic [31:0] seq, input logic [7:0] cnt);
      put(soh); put(8'h02); put_sb(seq, 0); put(cnt);
   endtask

   task automatic put_msg(input logic [7:0] pm, input bit onebyte, input logic [6:0] typ,
                          input logic [7:0][31:0] vals, input int zpad0, input logic [31:0] seqv,
                          input bit expect_rec);
      logic [7:0] b0;
      logic [7:0][31:0] e;
      put(8'h95);
      b0[7] = onebyte;
      for (int bb = 0; bb < 7; bb++) b0[6-bb] = pm[bb];
      put(b0);
      if (!onebyte) put({1'b1, pm[7], 6'b0});
      put({1'b1, typ});
      for (int i = 0; i < 8; i++) begin
         if (pm[i]) begin
            if (i >= 6 && typ[0]) for (int k = 3; k >= 0; k--) put(vals[i][8*k +: 8]);
            else put_sb(vals[i], (i == 0) ? zpad0 : 0);
            e[i] = vals[i];
         end else e[i] = INC[i] ? pv[i] + 32'd1 : pv[i];
      end
      if (expect_rec) begin
         pv = e;
         eq.push_back({seqv, {1'b0, typ}, e});
         tq.push_back(tag);
      end
   endtask

   task automatic end_packet(input int junk);
      logic [63:0] d;
      int nf;
      for (int j = 0; j < junk; j++) put(8'($urandom));
      while (bq.size() % 8 != 0) put(8'($urandom));
      nf = bq.size() / 8;
      for (int f = 0; f < nf; f++) begin
         for (int k = 0; k < 8; k++) d[8*k +: 8] = bq[8*f + k];
         fq_data.push_back(d);
         fq_last.push_back(f == nf - 1);
      end
      bq.delete();
   endtask

   task automatic run(input bit rnd, output int cyc);
      bit pend, held;
      logic [DW-1:0] hv;
      int drain;
      pend = 0; held = 0; hv = '0; drain = 0; cyc = 0;
      while (fq_data.size() > 0 || drain < 30) begin
         @(negedge clk);
         if (fq_data.size() > 0) begin
            in_valid = pend ? 1'b1 : (rnd ? ($urandom % 4 != 0) : 1'b1);
            in_data  = fq_data[0];
            in_last  = fq_last[0];
            cyc++;
         end else begin
            in_valid = 1'b0;
            drain++;
         end
         out_ready = (rnd && fq_data.size() > 0) ? ($urandom % 3 != 0) : 1'b1;
         #1;
         if (held) check(out_valid && outall == hv, "R10 record held under backpressure", outall, hv);
         held = out_valid && !out_ready;
         hv   = outall;
         if (out_valid && out_ready) begin
            if (eq.size() == 0) check(0, "R11 R12 R2 unexpected record", outall, '0);
            else begin
               check(outall == eq[0], tq[0], outall, eq[0]);
               void'(eq.pop_front());
               void'(tq.pop_front());
            end
         end
         if (in_valid && in_ready) begin
            void'(fq_data.pop_front());
            void'(fq_last.pop_front());
            pend = 0;
         end else pend = in_valid;
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int cyc;
      logic [7:0][31:0] v;
      logic [31:0] s0;
      logic [7:0] pm, cnt;
      repeat (5) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R1 out_valid low in reset", {295'd0, out_valid}, '0);
      @(negedge clk);
      rst = 1'b0;

      // R1, R9: first message all absent, ends on lane 6, followed by 10 junk frames
      tag = "R1 previous values cleared by reset";
      v = '0;
      hdr(8'h01, 32'd1, 8'd1);
      put_msg(8'h00, 1'b1, 7'd0, v, 0, 32'd1, 1'b1);
      end_packet(80);
      run(1'b0, cyc);
      check(cyc == 12, "R9 frame rate with one mid-frame completion", DW'(cyc), DW'(12));

      // R3 R4 R5 R7 R8: directed decoding across frames, then operators (R6)
      tag = "R3 R4 R5 R7 R8 directed decode";
      s0 = 32'h0001_2345;
      hdr(8'h01, s0, 8'd3);
      v[0] = 32'd5;         v[1] = 32'hFFFF_FFFF; v[2] = 32'd127;         v[3] = 32'd128;
      v[4] = 32'd0;         v[5] = 32'h0ABC_DEF0; v[6] = 32'hDEAD_BEEF;   v[7] = 32'h0102_0304;
      put_msg(8'hFF, 1'b0, 7'd1, v, 2, s0, 1'b1);
      tag = "R6 copy and increment with wrap";
      v[0] = 32'd300; v[2] = 32'd9;
      put_msg(8'b0000_0101, 1'b1, 7'd2, v, 0, s0 + 1, 1'b1);
      tag = "R7 plain bytes slot 7 only";
      v[7] = 32'hCAFE_0042;
      put_msg(8'h80, 1'b0, 7'd3, v, 0, s0 + 2, 1'b1);
      end_packet(5);
      run(1'b1, cyc);

      // R2 R12: rejected packets change nothing
      tag = "R2 bad start byte";
      hdr(8'h7E, 32'd50, 8'd1);
      v = {8{32'h1111_1111}};
      put_msg(8'hFF, 1'b0, 7'd0, v, 0, 32'd50, 1'b0);
      end_packet(3);
      tag = "R12 zero count";
      hdr(8'h01, 32'd60, 8'd0);
      put_msg(8'hFF, 1'b0, 7'd0, v, 0, 32'd60, 1'b0);
      end_packet(3);
      tag = "R2 R12 state kept after dropped packets";
      hdr(8'h01, 32'd70, 8'd1);
      put_msg(8'h00, 1'b1, 7'd4, v, 0, 32'd70, 1'b1);
      end_packet(9);
      run(1'b1, cyc);

      // random packets
      tag = "R6 R8 R11 random packets";
      for (int p = 0; p < 60; p++) begin
         s0  = $urandom;
         cnt = 8'(1 + $urandom % 4);
         hdr(8'h01, s0, cnt);
         for (int m = 0; m < int'(cnt); m++) begin
            pm = 8'($urandom);
            for (int i = 0; i < 8; i++) begin
               case ($urandom % 3)
                  0:       v[i] = $urandom % 128;
                  1:       v[i] = $urandom % 20000;
                  default: v[i] = $urandom;
               endcase
            end
            put_msg(pm, !pm[7] && ($urandom % 2 == 1), 7'($urandom), v, int'($urandom % 2),
                    s0 + m, 1'b1);
         end
         end_packet(int'($urandom % 14));
      end
      run(1'b1, cyc);

      check(eq.size() == 0, "R11 all expected records seen", DW'(eq.size()), '0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule